// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds and advances the 11-bit program counter of a small controller core. Each cycle the surrounding decode logic raises at most a few strobes: a plain advance, a conditional skip qualified by a zero result, an absolute jump, a subroutine call or a return. The block picks the winning action, forms the next PC and registers it. The PC visible on the output is the address of the instruction being executed.

Jump and call targets are absolute. They are built by placing the two page-select bits from the status register above a nine-bit operand address. A call saves the address of the instruction after it on an eight-entry return stack, and a return restores the most recent saved entry. When the stack is misused, the oldest entry is discarded or replicated, and a sticky fault flag records the event until reset.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pc_o` is 11'h7FF, `stack_fault_o` is 0 and the return stack is empty.
- R2: With only `step_i` raised, `pc_o` becomes its previous value plus 1, modulo 2048 (7FFh steps to 000h).
- R3: With no strobe raised, `pc_o` keeps its value.
- R4: With `skip_i` raised (no jump, call or return), `pc_o` advances by 2 when `zero_i` is 1 and by 1 when `zero_i` is 0, modulo 2048.
- R5: A jump loads `pc_o[10:9]` from `page_i` and `pc_o[8:0]` from `target_i`.
- R6: A call loads `pc_o` the same way as a jump and pushes the previous `pc_o` plus 1 as the return address.
- R7: A return loads `pc_o` with the most recently pushed address not yet popped, so eight nested calls unwind in last-in, first-out order.
- R8: A push onto a stack that already holds eight entries discards the oldest entry and sets `stack_fault_o`.
- R9: A return from an empty stack loads `pc_o` with the oldest entry that was last held (the bottom slot, kept in place on every pop) and sets `stack_fault_o`.
- R10: When several strobes are raised together, exactly one acts, with priority return, then call, then jump, then skip, then step.
- R11: Once set, `stack_fault_o` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance PC by one instruction |
| skip_i | input | 1 | Skip-capable operation in this cycle |
| zero_i | input | 1 | Result of the skip-capable operation is zero |
| jump_i | input | 1 | Absolute jump |
| call_i | input | 1 | Subroutine call |
| ret_i | input | 1 | Return from subroutine |
| target_i | input | 9 | Operand address of jump or call |
| page_i | input | 2 | Page-select bits from the status register |
| pc_o | output | 11 | Current program counter |
| stack_fault_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The interesting collision is a return arriving together with a call, which would both push and pop the stack in the same cycle; a jump or skip landing on top of either is the same kind of clash. The random phase raises each strobe independently, so all of these pairings occur many times, including at full and empty stack depths. A bench model applies the stated priority and tracks its own stack. Every cycle it compares the PC and the fault flag at the ports, and any cycle where the losing strobe leaked into the stack shows up as a wrong address on a later return.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_STEP = 3'd1,
      OP_SKIP = 3'd2,
      OP_JUMP = 3'd3,
      OP_CALL = 3'd4,
      OP_RET  = 3'd5
   } pc_op_e;

endpackage

// File: rtl/pcs_op_decode.sv
module pcs_op_decode
   import pcs_pkg::*;
(
   input  logic   step_i,
   input  logic   skip_i,
   input  logic   zero_i,
   input  logic   jump_i,
   input  logic   call_i,
   input  logic   ret_i,
   output pc_op_e op_o
);

   always_comb begin
      if (ret_i)                 op_o = OP_RET;
      else if (call_i)           op_o = OP_CALL;
      else if (jump_i)           op_o = OP_JUMP;
      else if (skip_i && zero_i) op_o = OP_SKIP;
      else if (skip_i || step_i) op_o = OP_STEP;
      else                       op_o = OP_HOLD;
   end

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
   import pcs_pkg::*;
#(
   parameter int PC_W   = 11,
   parameter int LOW_W  = 9,
   parameter int PAGE_W = 2
) (
   input  pc_op_e            op_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [LOW_W-1:0]  target_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [PC_W-1:0]   top_i,
   output logic [PC_W-1:0]   pc_next_o,
   output logic [PC_W-1:0]   ret_addr_o
);

   localparam logic [PC_W-1:0] ONE = PC_W'(1);
   localparam logic [PC_W-1:0] TWO = PC_W'(2);

   logic [PC_W-1:0] absolute;

   generate
      if (PC_W != LOW_W + PAGE_W) begin : g_bad_split
         $error("pcs_next_pc: PC_W must equal LOW_W + PAGE_W");
      end
      if (PAGE_W > 0) begin : g_paged
         assign absolute = {page_i, target_i};
      end else begin : g_flat
         assign absolute = PC_W'(target_i);
      end
   endgenerate

   assign ret_addr_o = pc_i + ONE;

   always_comb begin
      case (op_i)
         OP_STEP: pc_next_o = pc_i + ONE;
         OP_SKIP: pc_next_o = pc_i + TWO;
         OP_JUMP: pc_next_o = absolute;
         OP_CALL: pc_next_o = absolute;
         OP_RET:  pc_next_o = top_i;
         default: pc_next_o = pc_i;
      endcase
   end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
   parameter int W     = 11,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] top_o,
   output logic         fault_o
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [W-1:0]     slot [DEPTH];
   logic [CNT_W-1:0] level;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pcs_ret_stack: DEPTH must be at least 2");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot[i] <= '0;
            end else if (push_i) begin
               if (i == 0) slot[i] <= data_i;
               else        slot[i] <= slot[(i == 0) ? 0 : i-1];
            end else if (pop_i) begin
               if (i != DEPTH-1) slot[i] <= slot[(i == DEPTH-1) ? i : i+1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level   <= '0;
         fault_o <= 1'b0;
      end else if (push_i) begin
         if (level == FULL) fault_o <= 1'b1;
         else               level   <= level + 1'b1;
      end else if (pop_i) begin
         if (level == '0) fault_o <= 1'b1;
         else             level   <= level - 1'b1;
      end
   end

   assign top_o = slot[0];

   assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL);

   assert_push_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_o == $past(data_i));

   assert_underflow_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && level == '0) |=> fault_o);

   assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && level == FULL) |=> fault_o);

   assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> fault_o);

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcs_pkg::*;
#(
   parameter int PC_W        = 11,
   parameter int LOW_W       = 9,
   parameter int PAGE_W      = 2,
   parameter int STACK_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              skip_i,
   input  logic              zero_i,
   input  logic              jump_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [LOW_W-1:0]  target_i,
   input  logic [PAGE_W-1:0] page_i,
   output logic [PC_W-1:0]   pc_o,
   output logic              stack_fault_o
);

   localparam logic [PC_W-1:0] RESET_PC = '1;

   pc_op_e          op;
   logic [PC_W-1:0] pc_next;
   logic [PC_W-1:0] ret_addr;
   logic [PC_W-1:0] stack_top;

   pcs_op_decode i_decode (
      .step_i (step_i),
      .skip_i (skip_i),
      .zero_i (zero_i),
      .jump_i (jump_i),
      .call_i (call_i),
      .ret_i  (ret_i),
      .op_o   (op)
   );

   pcs_next_pc #(
      .PC_W   (PC_W),
      .LOW_W  (LOW_W),
      .PAGE_W (PAGE_W)
   ) i_next (
      .op_i       (op),
      .pc_i       (pc_o),
      .target_i   (target_i),
      .page_i     (page_i),
      .top_i      (stack_top),
      .pc_next_o  (pc_next),
      .ret_addr_o (ret_addr)
   );

   pcs_ret_stack #(
      .W     (PC_W),
      .DEPTH (STACK_DEPTH)
   ) i_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (op == OP_CALL),
      .pop_i   (op == OP_RET),
      .data_i  (ret_addr),
      .top_o   (stack_top),
      .fault_o (stack_fault_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_o <= RESET_PC;
      else        pc_o <= pc_next;
   end

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !skip_i && !jump_i && !call_i && !ret_i)
      |=> pc_o == $past(pc_o) + PC_W'(1));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !skip_i && !jump_i && !call_i && !ret_i) |=> $stable(pc_o));

   assert_skip_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_i && zero_i && !jump_i && !call_i && !ret_i)
      |=> pc_o == $past(pc_o) + PC_W'(2));

   assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_i && !call_i && !ret_i)
      |=> pc_o == {$past(page_i), $past(target_i)});

   assert_call_pushes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i) |=> stack_top == $past(pc_o) + PC_W'(1));

   assert_ret_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |=> pc_o == $past(stack_top));

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 0, skip_i = 0, zero_i = 0, jump_i = 0, call_i = 0, ret_i = 0;
   logic [8:0]  target_i = '0;
   logic [1:0]  page_i = '0;
   logic [10:0] pc_o;
   logic        stack_fault_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [10:0] m_pc;
   logic [10:0] m_stk [8];
   int          m_depth;
   bit          m_flag;

   always #2 clk = ~clk;

   pc_sequencer i_pc_sequencer (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .skip_i(skip_i), .zero_i(zero_i),
      .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i), .target_i(target_i),
      .page_i(page_i), .pc_o(pc_o), .stack_fault_o(stack_fault_o));

   function automatic logic [10:0] abs_target(input logic [1:0] pg, input logic [8:0] t);
      return {pg, t};
   endfunction

   task automatic model_reset();
      m_pc = 11'h7FF;
      m_depth = 0;
      m_flag = 0;
      for (int i = 0; i < 8; i++) m_stk[i] = '0;
   endtask

   task automatic model_step();
      logic [10:0] top;
      if (ret_i) begin
         top = m_stk[0];
         for (int i = 0; i < 7; i++) m_stk[i] = m_stk[i+1];
         if (m_depth == 0) m_flag = 1; else m_depth--;
         m_pc = top;
      end else if (call_i) begin
         for (int i = 7; i > 0; i--) m_stk[i] = m_stk[i-1];
         m_stk[0] = m_pc + 11'd1;
         if (m_depth == 8) m_flag = 1; else m_depth++;
         m_pc = abs_target(page_i, target_i);
      end else if (jump_i) begin
         m_pc = abs_target(page_i, target_i);
      end else if (skip_i) begin
         m_pc = m_pc + (zero_i ? 11'd2 : 11'd1);
      end else if (step_i) begin
         m_pc = m_pc + 11'd1;
      end
   endtask

   task automatic compare(input string tag);
      checks++;
      if (pc_o !== m_pc || stack_fault_o !== m_flag) begin
         errors++;
         $display("FAIL %s: pc=%h fault=%b expected pc=%h fault=%b",
                  tag, pc_o, stack_fault_o, m_pc, m_flag);
      end
   endtask

   // called at a negedge; applies inputs for one clock and checks at the next negedge
   task automatic apply(input bit st, sk, z, j, c, r,
                        input logic [1:0] pg, input logic [8:0] t, input string tag);
      step_i = st; skip_i = sk; zero_i = z; jump_i = j; call_i = c; ret_i = r;
      page_i = pg; target_i = t;
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset();
      rst_n = 0;
      step_i = 0; skip_i = 0; zero_i = 0; jump_i = 0; call_i = 0; ret_i = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
      compare("R1 reset state");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      do_reset();
      // R2 wrap from 7FF to 000
      apply(1,0,0,0,0,0, 2'd0, 9'd0, "R2 step wraps");
      apply(1,0,0,0,0,0, 2'd0, 9'd0, "R2 step");
      apply(0,0,0,0,0,0, 2'd0, 9'd0, "R3 hold");
      apply(0,0,1,0,0,0, 2'd3, 9'h1FF, "R3 hold with data");
      apply(0,1,1,0,0,0, 2'd0, 9'd0, "R4 skip zero");
      apply(0,1,0,0,0,0, 2'd0, 9'd0, "R4 skip nonzero");
      apply(1,1,1,0,0,0, 2'd0, 9'd0, "R10 skip over step");
      apply(0,0,0,1,0,0, 2'd2, 9'h1A5, "R5 jump paged");
      apply(0,0,0,1,0,0, 2'd1, 9'h003, "R5 jump page1");
      // nine nested calls: ninth overflows
      for (int k = 0; k < 9; k++)
         apply(0,0,0,0,1,0, 2'(k), 9'(k*37+5), k == 8 ? "R8 ninth push" : "R6 call");
      for (int k = 0; k < 10; k++)
         apply(0,0,0,0,0,1, 2'd0, 9'd0, k >= 8 ? "R9 pop empty" : "R7 return");
      apply(1,0,0,0,0,0, 2'd0, 9'd0, "R11 flag held");
      do_reset();
      apply(0,0,0,1,0,0, 2'd1, 9'h010, "R5 jump");
      apply(0,0,0,0,1,0, 2'd3, 9'h0F0, "R6 call");
      apply(1,1,1,1,1,1, 2'd2, 9'h044, "R10 return beats all");
      apply(1,1,1,1,1,0, 2'd2, 9'h044, "R10 call beats jump");
      apply(1,1,1,1,0,0, 2'd1, 9'h077, "R10 jump beats skip");
      apply(0,0,0,0,0,1, 2'd0, 9'd0, "R7 return");
      apply(0,0,0,0,0,1, 2'd0, 9'd0, "R9 underflow");
      apply(0,0,0,0,0,0, 2'd0, 9'd0, "R11 flag held");
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r;
         bit st, sk, z, j, c, rt;
         string tag;
         r = $urandom;
         st = r[2:0] != 0;
         sk = r[5:3] == 0;
         z  = r[6];
         j  = r[10:7] == 0;
         c  = r[14:11] < 2;
         rt = r[18:15] < 2;
         if (int'(rt) + int'(c) + int'(j) + int'(sk) + int'(st) > 1) tag = "R10 mixed";
         else if (rt) tag = "R7 random return";
         else if (c)  tag = "R6 random call";
         else if (j)  tag = "R5 random jump";
         else if (sk) tag = "R4 random skip";
         else if (st) tag = "R2 random step";
         else         tag = "R3 random hold";
         apply(st, sk, z, j, c, rt, r[20:19], r[29:21], tag);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule